// File: doc/BRIEF.md
# Branch Target Buffer

This block is a small set-associative cache that the fetch stage looks up with the current fetch address. The lookup is combinational, so a hit, a stored taken bit and a stored target come back in the same cycle. The next-PC logic can then steer fetch before the instruction is decoded. Each entry keeps the complete upper address of its branch as a tag. A hit therefore means the fetched word is exactly the branch that was recorded.

A second port reports each resolved branch with its address, its actual direction and its actual target. If that branch is already present and was predicted right, only its recency is refreshed. If it is present and was predicted wrong, its direction bit is rewritten, and its target is rewritten too when the branch went taken. If it is absent and went taken, a way is allocated. An absent branch that fell through leaves the buffer as it is.

The default geometry is 16 sets of 4 ways over 32-bit addresses. The set is chosen by address bits [5:2], and bits [31:6] form the tag. Within a set, the victim is an empty way if one exists, otherwise the least recently used way. Recency is refreshed by fetch hits and by resolve writes.

Top module: `branch_target_buffer`

## Requirements
- R1: After reset every entry is empty, so no lookup hits until a taken branch has been resolved.
- R2: A lookup hits only when set bits [5:2] select the set and bits [31:6] equal the stored tag of a valid way. An address that differs in either field misses.
- R3: On a hit, `predTaken` and `predTarget` show the stored bit and address in the same cycle as `fetchPc`. On a miss both outputs are zero.
- R4: A taken resolve that misses allocates an entry. From the next cycle, a lookup of that address hits as taken with the resolved target.
- R5: A not-taken resolve that misses leaves the buffer unchanged, and a later lookup of that address still misses.
- R6: A resolve that hits and agrees with the stored direction (and, when taken, with the stored target) leaves the stored bit and target unchanged.
- R7: A resolve that hits with the opposite direction rewrites the taken bit. The target is replaced only when the actual outcome is taken; a not-taken outcome keeps the old target.
- R8: A resolve that hits as taken with the stored bit set but a different target replaces the target.
- R9: Allocation uses an empty way of the set while one exists, so four taken branches mapping to one set all stay resident.
- R10: With the set full, allocation evicts the way used least recently. Both lookups with `fetchValid` high that hit and resolves that hit count as a use.
- R11: A lookup and a resolve to the same set in one cycle both take effect. The lookup returns the contents from before that cycle's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | Lookup is real; its hit refreshes recency |
| fetchPc | input | 32 | Address being fetched |
| predHit | output | 1 | Lookup found the branch |
| predTaken | output | 1 | Stored direction of the hit entry |
| predTarget | output | 32 | Stored target of the hit entry |
| resolveValid | input | 1 | A branch outcome is reported this cycle |
| resolvePc | input | 32 | Address of the resolved branch |
| resolveTaken | input | 1 | Actual direction |
| resolveTarget | input | 32 | Actual target |

## Verification
Corrupted tag or valid state shows up in the same cycle as a false hit or a missing hit on `predHit`. A wrong data write shows up one cycle after the resolve, when the next lookup of that address returns a stale bit or a stale target. Damaged recency order stays hidden until the set is full and an allocation evicts a way. The eviction then appears as a miss on a branch that should have survived, or as a hit on the one that should have left. For this reason the stimulus fills sets and forces evictions after fetch-side and resolve-side refreshes.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int ADDR_W  = 32;
  localparam int SET_CNT = 16;
  localparam int WAY_CNT = 4;
  localparam int IDX_LO  = 2;
  localparam int IDX_W   = $clog2(SET_CNT);
  localparam int WAY_W   = $clog2(WAY_CNT);
  localparam int TAG_LO  = IDX_LO + IDX_W;
  localparam int TAG_W   = ADDR_W - TAG_LO;

  typedef logic [WAY_CNT-1:0][WAY_W-1:0] rank_t;

  // Write strobes from control to datapath
  typedef struct packed {
    logic             wrEn;
    logic             wrAlloc;
    logic             wrTarget;
    logic [WAY_W-1:0] wrWay;
  } btb_strobe_t;
endpackage

// File: rtl/btb_datapath.sv
module btb_datapath
  import btb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic [ADDR_W-1:0] resolvePc,
  input  logic              resolveTaken,
  input  logic [ADDR_W-1:0] resolveTarget,
  input  btb_strobe_t       strobe,
  output logic [WAY_CNT-1:0] fetchMatch,
  output logic [WAY_CNT-1:0] resolveMatch,
  output logic [WAY_CNT-1:0] resolveValidVec,
  output logic              storedTaken,
  output logic [ADDR_W-1:0] storedTarget,
  output logic              predHit,
  output logic              predTaken,
  output logic [ADDR_W-1:0] predTarget
);
  logic              entValid  [SET_CNT][WAY_CNT];
  logic [TAG_W-1:0]  entTag    [SET_CNT][WAY_CNT];
  logic [ADDR_W-1:0] entTarget [SET_CNT][WAY_CNT];
  logic              entTaken  [SET_CNT][WAY_CNT];

  logic [IDX_W-1:0] fIdx, rIdx;
  logic [TAG_W-1:0] fTag, rTag;

  assign fIdx = fetchPc[TAG_LO-1:IDX_LO];
  assign fTag = fetchPc[ADDR_W-1:TAG_LO];
  assign rIdx = resolvePc[TAG_LO-1:IDX_LO];
  assign rTag = resolvePc[ADDR_W-1:TAG_LO];

  for (genvar w = 0; w < WAY_CNT; w++) begin : g_cmp
    assign fetchMatch[w]      = entValid[fIdx][w] && (entTag[fIdx][w] == fTag);
    assign resolveMatch[w]    = entValid[rIdx][w] && (entTag[rIdx][w] == rTag);
    assign resolveValidVec[w] = entValid[rIdx][w];
  end

  always_comb begin
    predHit      = 1'b0;
    predTaken    = 1'b0;
    predTarget   = '0;
    storedTaken  = 1'b0;
    storedTarget = '0;
    for (int w = 0; w < WAY_CNT; w++) begin
      if (fetchMatch[w]) begin
        predHit    = 1'b1;
        predTaken  = entTaken[fIdx][w];
        predTarget = entTarget[fIdx][w];
      end
      if (resolveMatch[w]) begin
        storedTaken  = entTaken[rIdx][w];
        storedTarget = entTarget[rIdx][w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SET_CNT; s++)
        for (int w = 0; w < WAY_CNT; w++)
          entValid[s][w] <= 1'b0;
    end else if (strobe.wrEn && strobe.wrAlloc) begin
      entValid[rIdx][strobe.wrWay] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      entTaken[rIdx][strobe.wrWay] <= resolveTaken;
      if (strobe.wrAlloc)  entTag[rIdx][strobe.wrWay]    <= rTag;
      if (strobe.wrTarget) entTarget[rIdx][strobe.wrWay] <= resolveTarget;
    end
  end
endmodule

// File: rtl/btb_control.sv
module btb_control
  import btb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               fetchValid,
  input  logic [ADDR_W-1:0]  fetchPc,
  input  logic [WAY_CNT-1:0] fetchMatch,
  input  logic               resolveValid,
  input  logic [ADDR_W-1:0]  resolvePc,
  input  logic               resolveTaken,
  input  logic [ADDR_W-1:0]  resolveTarget,
  input  logic [WAY_CNT-1:0] resolveMatch,
  input  logic [WAY_CNT-1:0] resolveValidVec,
  input  logic               storedTaken,
  input  logic [ADDR_W-1:0]  storedTarget,
  output btb_strobe_t        strobe
);
  rank_t lruRank [SET_CNT];
  rank_t lruNext [SET_CNT];

  logic [IDX_W-1:0] fIdx, rIdx;
  logic [WAY_W-1:0] fWay, rWay, victimWay, lruWay;
  logic             fHit, rHit, agree, doAlloc, doFix, emptyFound;

  assign fIdx = fetchPc[TAG_LO-1:IDX_LO];
  assign rIdx = resolvePc[TAG_LO-1:IDX_LO];
  assign fHit = |fetchMatch;
  assign rHit = |resolveMatch;

  function automatic logic [WAY_W-1:0] encodeWay(input logic [WAY_CNT-1:0] vec);
    encodeWay = '0;
    for (int w = 0; w < WAY_CNT; w++)
      if (vec[w]) encodeWay = WAY_W'(w);
  endfunction

  // Make one way most recent; ways younger than it age by one
  function automatic rank_t touchRank(input rank_t r, input logic [WAY_W-1:0] way);
    touchRank = r;
    for (int i = 0; i < WAY_CNT; i++) begin
      if (WAY_W'(i) == way)   touchRank[i] = '0;
      else if (r[i] < r[way]) touchRank[i] = r[i] + 1'b1;
    end
  endfunction

  assign fWay = encodeWay(fetchMatch);
  assign rWay = encodeWay(resolveMatch);

  always_comb begin
    lruWay     = '0;
    victimWay  = '0;
    emptyFound = 1'b0;
    for (int w = 0; w < WAY_CNT; w++)
      if (lruRank[rIdx][w] == WAY_W'(WAY_CNT - 1)) lruWay = WAY_W'(w);
    for (int w = 0; w < WAY_CNT; w++) begin
      if (!resolveValidVec[w] && !emptyFound) begin
        victimWay  = WAY_W'(w);
        emptyFound = 1'b1;
      end
    end
    if (!emptyFound) victimWay = lruWay;
  end

  assign agree   = (storedTaken == resolveTaken) &&
                   (!resolveTaken || (storedTarget == resolveTarget));
  assign doAlloc = resolveValid && !rHit && resolveTaken;
  assign doFix   = resolveValid && rHit && !agree;

  always_comb begin
    strobe.wrEn     = doAlloc || doFix;
    strobe.wrAlloc  = doAlloc;
    strobe.wrTarget = resolveTaken;
    strobe.wrWay    = doAlloc ? victimWay : rWay;
  end

  // Lookup refresh first, then resolve refresh, so same-set events compose
  always_comb begin
    lruNext = lruRank;
    if (fetchValid && fHit)
      lruNext[fIdx] = touchRank(lruNext[fIdx], fWay);
    if (resolveValid && (rHit || doAlloc))
      lruNext[rIdx] = touchRank(lruNext[rIdx], doAlloc ? victimWay : rWay);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SET_CNT; s++)
        for (int w = 0; w < WAY_CNT; w++)
          lruRank[s][w] <= WAY_W'(w);
    end else begin
      lruRank <= lruNext;
    end
  end
endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer
  import btb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchPc,
  output logic              predHit,
  output logic              predTaken,
  output logic [ADDR_W-1:0] predTarget,
  input  logic              resolveValid,
  input  logic [ADDR_W-1:0] resolvePc,
  input  logic              resolveTaken,
  input  logic [ADDR_W-1:0] resolveTarget
);
  btb_strobe_t        strobe;
  logic [WAY_CNT-1:0] fetchMatch, resolveMatch, resolveValidVec;
  logic               storedTaken;
  logic [ADDR_W-1:0]  storedTarget;

  btb_control u_ctrl (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchPc(fetchPc),
    .fetchMatch(fetchMatch), .resolveValid(resolveValid), .resolvePc(resolvePc),
    .resolveTaken(resolveTaken), .resolveTarget(resolveTarget),
    .resolveMatch(resolveMatch), .resolveValidVec(resolveValidVec),
    .storedTaken(storedTaken), .storedTarget(storedTarget), .strobe(strobe)
  );

  btb_datapath u_dp (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .resolvePc(resolvePc),
    .resolveTaken(resolveTaken), .resolveTarget(resolveTarget), .strobe(strobe),
    .fetchMatch(fetchMatch), .resolveMatch(resolveMatch),
    .resolveValidVec(resolveValidVec), .storedTaken(storedTaken),
    .storedTarget(storedTarget), .predHit(predHit), .predTaken(predTaken),
    .predTarget(predTarget)
  );
endmodule

// File: rtl/btb_checker.sv
module btb_checker
  import btb_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] fetchPc,
  input logic              predHit,
  input logic              predTaken,
  input logic [ADDR_W-1:0] predTarget,
  input logic              resolveValid,
  input logic [ADDR_W-1:0] resolvePc,
  input logic              resolveTaken,
  input logic [ADDR_W-1:0] resolveTarget,
  input logic [WAY_CNT-1:0] fetchMatch,
  input logic [WAY_CNT-1:0] resolveMatch
);
  logic pastOk;
  always_ff @(posedge clk) pastOk <= rstN;

  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    !pastOk |-> !predHit); // R1

  AST_MISS_OUTPUTS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !predHit |-> (!predTaken && predTarget == '0)); // R3

  AST_TAKEN_VISIBLE_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(resolveValid && resolveTaken) && fetchPc == $past(resolvePc))
    |-> (predHit && predTaken && predTarget == $past(resolveTarget))); // R4

  AST_NOT_TAKEN_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(resolveValid && !resolveTaken) && fetchPc == $past(resolvePc))
    |-> !predTaken); // R7

  AST_UNIQUE_FETCH_WAY: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fetchMatch)); // R9

  AST_UNIQUE_RESOLVE_WAY: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(resolveMatch)); // R9
endmodule

bind branch_target_buffer btb_checker u_chk (
  .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .predHit(predHit),
  .predTaken(predTaken), .predTarget(predTarget), .resolveValid(resolveValid),
  .resolvePc(resolvePc), .resolveTaken(resolveTaken), .resolveTarget(resolveTarget),
  .fetchMatch(fetchMatch), .resolveMatch(resolveMatch)
);

// File: tb/branch_target_buffer_tb.sv
module branch_target_buffer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 37;

  typedef struct packed {
    logic        fv;
    logic [7:0]  fTag;
    logic [3:0]  fSet;
    logic        rv;
    logic [7:0]  rTag;
    logic [3:0]  rSet;
    logic        rTk;
    logic [31:0] rTgt;
    logic        eHit;
    logic        eTk;
    logic [31:0] eTgt;
    logic [3:0]  req;
  } vec_t;

  // Lookup results are those before the same vector's resolve is written
  localparam vec_t VECS [NVEC] = '{
    '{1, 1,1, 0, 0,0,0,'h0,    0,0,'h0,    1},  // R1 empty
    '{1, 1,1, 1, 1,1,1,'h1000, 0,0,'h0,   11},  // R11 same cycle
    '{1, 1,1, 0, 0,0,0,'h0,    1,1,'h1000, 4},  // R4 allocated
    '{1, 2,1, 1, 2,1,0,'h5555, 0,0,'h0,    5},  // R5
    '{1, 2,1, 0, 0,0,0,'h0,    0,0,'h0,    5},  // R5 still absent
    '{1, 1,2, 0, 0,0,0,'h0,    0,0,'h0,    2},  // R2 other set
    '{1, 3,1, 0, 0,0,0,'h0,    0,0,'h0,    2},  // R2 other tag
    '{1, 1,1, 1, 1,1,1,'h1000, 1,1,'h1000, 6},  // R6 correct
    '{1, 1,1, 0, 0,0,0,'h0,    1,1,'h1000, 6},  // R6 unchanged
    '{1, 1,1, 1, 1,1,0,'h7777, 1,1,'h1000, 3},  // R3
    '{1, 1,1, 0, 0,0,0,'h0,    1,0,'h1000, 7},  // R7 bit cleared, target kept
    '{1, 1,1, 1, 1,1,1,'h2000, 1,0,'h1000, 7},  // R7
    '{1, 1,1, 0, 0,0,0,'h0,    1,1,'h2000, 7},  // R7 set, target replaced
    '{0, 0,0, 1, 1,1,1,'h3000, 0,0,'h0,    8},  // R8
    '{1, 1,1, 0, 0,0,0,'h0,    1,1,'h3000, 8},  // R8 new target
    '{0, 0,0, 1,10,5,1,'hA00,  0,0,'h0,    9},  // R9 fill set 5
    '{0, 0,0, 1,11,5,1,'hB00,  0,0,'h0,    9},
    '{0, 0,0, 1,12,5,1,'hC00,  0,0,'h0,    9},
    '{0, 0,0, 1,13,5,1,'hD00,  0,0,'h0,    9},
    '{1,10,5, 0, 0,0,0,'h0,    1,1,'hA00, 10},  // R10 fetch refresh
    '{0, 0,0, 1,14,5,1,'hE00,  0,0,'h0,   10},  // R10 evicts 11
    '{1,11,5, 0, 0,0,0,'h0,    0,0,'h0,   10},
    '{0, 0,0, 1,12,5,1,'hC00,  0,0,'h0,   10},  // R10 resolve refresh
    '{0, 0,0, 1,15,5,1,'hF00,  0,0,'h0,   10},  // R10 evicts 13
    '{1,13,5, 0, 0,0,0,'h0,    0,0,'h0,   10},
    '{1,12,5, 0, 0,0,0,'h0,    1,1,'hC00, 10},
    '{1,10,5, 0, 0,0,0,'h0,    1,1,'hA00, 10},
    '{1,14,5, 0, 0,0,0,'h0,    1,1,'hE00, 10},
    '{1,15,5, 0, 0,0,0,'h0,    1,1,'hF00, 10},
    '{0, 0,0, 1,20,7,1,'h2000, 0,0,'h0,    9},  // R9 fill set 7
    '{0, 0,0, 1,21,7,1,'h2100, 0,0,'h0,    9},
    '{0, 0,0, 1,22,7,1,'h2200, 0,0,'h0,    9},
    '{0, 0,0, 1,23,7,1,'h2300, 0,0,'h0,    9},
    '{1,20,7, 0, 0,0,0,'h0,    1,1,'h2000, 9},  // R9 all resident
    '{1,21,7, 0, 0,0,0,'h0,    1,1,'h2100, 9},
    '{1,22,7, 0, 0,0,0,'h0,    1,1,'h2200, 9},
    '{1,23,7, 0, 0,0,0,'h0,    1,1,'h2300, 9}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchPc = '0;
  logic        predHit, predTaken;
  logic [31:0] predTarget;
  logic        resolveValid = 1'b0;
  logic [31:0] resolvePc = '0;
  logic        resolveTaken = 1'b0;
  logic [31:0] resolveTarget = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_target_buffer u_dut (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchPc(fetchPc),
    .predHit(predHit), .predTaken(predTaken), .predTarget(predTarget),
    .resolveValid(resolveValid), .resolvePc(resolvePc),
    .resolveTaken(resolveTaken), .resolveTarget(resolveTarget)
  );

  function automatic logic [31:0] pcOf(input logic [7:0] tag, input logic [3:0] setIdx);
    return (32'(tag) << 6) | (32'(setIdx) << 2);
  endfunction

  task automatic expect32(input string what, input int req, input logic [31:0] act,
                          input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic lookupOnly(input logic [31:0] pc);
    @(negedge clk);
    fetchValid = 1'b1; fetchPc = pc; resolveValid = 1'b0;
    #(CLK_PERIOD/4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      fetchValid    = VECS[i].fv;
      fetchPc       = pcOf(VECS[i].fTag, VECS[i].fSet);
      resolveValid  = VECS[i].rv;
      resolvePc     = pcOf(VECS[i].rTag, VECS[i].rSet);
      resolveTaken  = VECS[i].rTk;
      resolveTarget = VECS[i].rTgt;
      #(CLK_PERIOD/4);
      expect32("hit", int'(VECS[i].req), 32'(predHit), 32'(VECS[i].eHit));
      if (VECS[i].eHit) begin
        expect32("taken", int'(VECS[i].req), 32'(predTaken), 32'(VECS[i].eTk));
        expect32("target", int'(VECS[i].req), predTarget, VECS[i].eTgt);
      end
    end
    // R1: a reset mid-run empties every set
    @(negedge clk);
    resolveValid = 1'b0; fetchValid = 1'b0; rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    lookupOnly(pcOf(8'd1, 4'd1));
    expect32("hit after reset (R1)", 1, 32'(predHit), 32'd0);
    lookupOnly(pcOf(8'd15, 4'd5));
    expect32("hit after reset (R1)", 1, 32'(predHit), 32'd0);
    // R3: miss outputs stay zero
    expect32("taken on miss (R3)", 3, 32'(predTaken), 32'd0);
    expect32("target on miss (R3)", 3, predTarget, 32'd0);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule